// File: doc/BRIEF.md
# Read Gate Sync Search Controller

This block sits behind the byte assembler of a disk read path and decides when the external phase-locked loop is told to lock. It scans each valid decoded byte for a run of preamble bytes. Once the run is long enough it raises the read gate and opens a window that counts bytes while it waits for an address-mark indication from the mark decoder.

If a mark arrives inside the window, the gate stays high until the read path signals that the field has ended. If the window runs out first, the gate drops and the search starts again from an empty run.

The recording density selects both the run length and the window size. In single density, only zero bytes count as preamble. In double density, zero bytes and all-ones bytes both count.

Top module: `rd_gate_hunt`

## Requirements
- R1: While `rst_n` or `search_en` is low, `rd_gate` is low one clock later, and both counters are emptied. After re-enable, a complete new preamble run is needed before the gate rises.
- R2: With `fm_sel`=1, `rd_gate` goes high on the clock after the edge that samples the second consecutive valid byte equal to 8'h00.
- R3: With `fm_sel`=0, `rd_gate` goes high after four consecutive valid bytes, each of which is 8'h00 or 8'hFF in any mixture.
- R4: With `fm_sel`=1, a byte of 8'hFF is not preamble and breaks the run.
- R5: A valid byte that is not a preamble value resets the run count to zero, so a full new run is needed.
- R6: Cycles with `byte_vld` low neither extend nor break the run or the window count.
- R7: With `fm_sel`=1 and no mark, `rd_gate` falls on the clock after the 10th valid byte that follows the gate rising.
- R8: With `fm_sel`=0 and no mark, `rd_gate` falls on the clock after the 16th valid byte that follows the gate rising.
- R9: After `mark_hit` is seen while the window is open, `rd_gate` stays high for any number of further bytes, until `field_end` or disable.
- R10: `field_end` drops `rd_gate` on the next clock, from any state, and returns the block to searching with an empty run.
- R11: `mark_hit` has no effect while the block is searching (gate low).
- R12: A `mark_hit` on the same cycle as the last byte of the window counts as found, and the gate stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| search_en | input | 1 | Enables searching; low holds the block idle |
| fm_sel | input | 1 | 1 selects single density (FM), 0 selects double density (MFM) |
| byte_vld | input | 1 | Strobe marking a valid decoded byte |
| byte_data | input | 8 | Decoded byte value |
| mark_hit | input | 1 | Address mark detected pulse |
| field_end | input | 1 | End of useful field data pulse |
| rd_gate | output | 1 | Read gate to the external PLL |

## Verification
Single-density zero runs are contrasted with all-ones runs, which tell apart the density-dependent preamble set. Double-density mixtures of 00 and FF bytes check that either value counts. Runs interrupted by a foreign byte are compared with runs interrupted only by idle cycles, which separates a broken run from a paused one. Windows are left to expire in both densities, closed by a mark mid-window, and closed by a mark on exactly the last byte; these cases pin the window length and the priority of the mark over the window end. Stray marks while searching, and field-end or disable arriving in every state, confirm that the block returns to a clean search.

// File: rtl/rd_gate_hunt.sv
module rd_gate_hunt #(
  parameter int FM_RUN  = 2,
  parameter int MFM_RUN = 4,
  parameter int FM_WIN  = 10,
  parameter int MFM_WIN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       search_en,
  input  logic       fm_sel,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       mark_hit,
  input  logic       field_end,
  output logic       rd_gate
);

  localparam int RUN_MAX = (FM_RUN > MFM_RUN) ? FM_RUN : MFM_RUN;
  localparam int WIN_MAX = (FM_WIN > MFM_WIN) ? FM_WIN : MFM_WIN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int WIN_W   = $clog2(WIN_MAX + 1);

  typedef enum logic [1:0] {HUNT, ARMED, HELD} st_t;

  st_t              st;
  logic [RUN_W-1:0] run_cnt;
  logic [WIN_W-1:0] win_cnt;

  wire              is_sync  = (byte_data == 8'h00) || (!fm_sel && byte_data == 8'hFF);
  wire [RUN_W-1:0]  run_need = fm_sel ? RUN_W'(FM_RUN) : RUN_W'(MFM_RUN);
  wire [WIN_W-1:0]  win_lim  = fm_sel ? WIN_W'(FM_WIN) : WIN_W'(MFM_WIN);
  wire [RUN_W-1:0]  run_nxt  = run_cnt + 1'b1;
  wire [WIN_W-1:0]  win_nxt  = win_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !search_en || field_end) begin
      st      <= HUNT;
      run_cnt <= '0;
      win_cnt <= '0;
    end else begin
      case (st)
        HUNT: if (byte_vld) begin
          if (!is_sync) begin
            run_cnt <= '0;
          end else if (run_nxt >= run_need) begin
            run_cnt <= '0;
            win_cnt <= '0;
            st      <= ARMED;
          end else begin
            run_cnt <= run_nxt;
          end
        end
        ARMED: if (mark_hit) begin
          win_cnt <= '0;
          st      <= HELD;
        end else if (byte_vld) begin
          if (win_nxt >= win_lim) begin
            win_cnt <= '0;
            st      <= HUNT;
          end else begin
            win_cnt <= win_nxt;
          end
        end
        HELD: ;
        default: st <= HUNT;
      endcase
    end
  end

  assign rd_gate = (st != HUNT);

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> !rd_gate);

  p_end_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> !rd_gate);

  p_rise_on_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_gate) |-> $past(byte_vld && is_sync));

  p_held_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HELD && search_en && !field_end) |=> rd_gate);

  p_win_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt < WIN_W'(WIN_MAX));

  p_no_mark_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HUNT) |=> (st != HELD));

endmodule

// File: tb/rd_gate_hunt_bench.sv
module rd_gate_hunt_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, search_en = 1'b0, fm_sel = 1'b1;
  logic byte_vld = 1'b0, mark_hit = 1'b0, field_end = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic rd_gate;

  int vectors = 0, errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  // reference model state: 0 hunting, 1 window open, 2 locked
  int m_state = 0, m_run = 0, m_win = 0;
  bit exp_gate = 1'b0;

  always #5 clk = ~clk;

  rd_gate_hunt u_rd_gate_hunt (
    .clk(clk), .rst_n(rst_n), .search_en(search_en), .fm_sel(fm_sel),
    .byte_vld(byte_vld), .byte_data(byte_data), .mark_hit(mark_hit),
    .field_end(field_end), .rd_gate(rd_gate)
  );

  always @(posedge clk) begin
    bit sync;
    int need, lim;
    sync = (byte_data == 8'h00) || (!fm_sel && byte_data == 8'hFF);
    need = fm_sel ? 2 : 4;
    lim  = fm_sel ? 10 : 16;
    if (!rst_n || !search_en || field_end) begin
      m_state = 0; m_run = 0; m_win = 0;
    end else if (m_state == 1 && mark_hit) begin
      m_state = 2;
    end else if (m_state == 0 && byte_vld) begin
      if (!sync) m_run = 0;
      else begin
        m_run++;
        if (m_run >= need) begin m_state = 1; m_run = 0; m_win = 0; end
      end
    end else if (m_state == 1 && byte_vld) begin
      m_win++;
      if (m_win >= lim) begin m_state = 0; m_win = 0; end
    end
    exp_gate = (m_state != 0);
  end

  always @(negedge clk) if (!done) begin
    vectors++;
    if (rd_gate !== exp_gate) begin
      errors++;
      $display("FAIL %s: rd_gate=%0b expected=%0b at %0t", tag, rd_gate, exp_gate, $time);
    end
  end

  task automatic step(input bit v, input logic [7:0] d, input bit mk = 0, input bit fe = 0);
    @(negedge clk);
    byte_vld = v; byte_data = d; mark_hit = mk; field_end = fe;
  endtask

  task automatic expect_gate(input bit e, input string t);
    @(negedge clk);
    vectors++;
    if (rd_gate !== e) begin
      errors++;
      $display("FAIL %s: rd_gate=%0b expected=%0b (directed)", t, rd_gate, e);
    end
    byte_vld = 0; mark_hit = 0; field_end = 0;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h5A);
  endtask

  initial begin
    tag = "R1";
    quiet(3);
    rst_n = 1;
    step(1, 8'h00); step(1, 8'h00); step(1, 8'h00);
    expect_gate(0, "R1");
    search_en = 1;
    step(1, 8'h00);
    expect_gate(0, "R1");
    tag = "R2";
    step(1, 8'h00);
    expect_gate(1, "R2");
    tag = "R7";
    for (int i = 0; i < 9; i++) step(1, 8'h55);
    expect_gate(1, "R7");
    step(1, 8'h55);
    expect_gate(0, "R7");
    tag = "R4";
    step(1, 8'hFF); step(1, 8'hFF); step(1, 8'hFF);
    expect_gate(0, "R4");
    tag = "R5";
    step(1, 8'h00); step(1, 8'h12); step(1, 8'h00);
    expect_gate(0, "R5");
    tag = "R6";
    quiet(4);
    step(1, 8'h00);
    expect_gate(1, "R6");
    for (int i = 0; i < 5; i++) begin step(1, 8'h33); step(0, 8'h33); end
    for (int i = 0; i < 4; i++) step(1, 8'h33);
    expect_gate(1, "R6");
    step(1, 8'h33);
    expect_gate(0, "R6");
    tag = "R11";
    step(0, 8'h00, 1); step(1, 8'h00, 1);
    expect_gate(0, "R11");
    step(1, 8'h77);
    tag = "R12";
    step(1, 8'h00); step(1, 8'h00);
    for (int i = 0; i < 9; i++) step(1, 8'hAA);
    step(1, 8'hAA, 1);
    for (int i = 0; i < 20; i++) step(1, 8'h42);
    expect_gate(1, "R12");
    tag = "R10";
    step(0, 8'h00, 0, 1);
    expect_gate(0, "R10");
    step(1, 8'h00);
    expect_gate(0, "R10");
    step(1, 8'h00);
    expect_gate(1, "R10");
    step(0, 8'h00, 0, 1);
    quiet(2);
    tag = "R3";
    fm_sel = 0;
    step(1, 8'h00); step(1, 8'hFF); step(1, 8'hFF);
    expect_gate(0, "R3");
    step(1, 8'h00);
    expect_gate(1, "R3");
    tag = "R8";
    for (int i = 0; i < 15; i++) step(1, 8'h4E);
    expect_gate(1, "R8");
    step(1, 8'h4E);
    expect_gate(0, "R8");
    tag = "R5";
    step(1, 8'hFF); step(1, 8'hFF); step(1, 8'hFF); step(1, 8'h01);
    step(1, 8'hFF); step(1, 8'h00); step(1, 8'hFF);
    expect_gate(0, "R5");
    tag = "R9";
    step(1, 8'h00);
    step(1, 8'h4E); step(0, 8'h4E, 1);
    for (int i = 0; i < 40; i++) step(1, 8'h4E);
    expect_gate(1, "R9");
    tag = "R1";
    search_en = 0;
    quiet(1);
    expect_gate(0, "R1");
    search_en = 1;
    step(1, 8'h00); step(1, 8'h00); step(1, 8'h00);
    expect_gate(0, "R1");
    step(1, 8'h00);
    expect_gate(1, "R1");
    quiet(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule